// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a register-mapped watchdog built on a 64-bit up-counter and a 64-bit period register. Both are seen on a 32-bit register bus as a low and a high word. Software first sets the mode and period registers. It then arms the watchdog with two key writes to the watchdog control register: an arm key followed by a confirm key. While armed, software must service the watchdog with the same two-key handshake before the counter reaches the period. Each completed service clears the counter.

A timeout happens when the counter reaches the period, or when a wrong key is written while the watchdog is armed. On a timeout the block sets a sticky flag, freezes the counter and raises a reset request for a fixed number of clock cycles. Once the arm key has been accepted, the counter, period and mode registers are locked. Only the key field of the control register still has an effect, plus a write-one-to-clear of the flag.

Top module: `key_watchdog`

## Requirements
- R1: After reset, reads return: the ID constant at byte offset 0x00, zero for the counter and period words, zero for the watchdog control word (offset 0x28), and zero for offset 0x04. The reset request is low.
- R2: In idle, a control write with key 0xA5C6 (bits 31:16) and the enable bit (bit 14) set moves to pre-active. The enable bit then reads back as 1. The same key with the enable bit clear leaves the block idle.
- R3: The counter increments once per clock only when all of the following hold: the block is armed (active or service state), global control (0x24) bits 3:2 equal 2, global control bits 1:0 equal 3, and timer control (0x20) bits 7:6 equal 2. With any other setting it holds its value and no timeout occurs.
- R4: In pre-active, a control write with key 0xDA7E and the enable bit set moves to active. Any other control write returns the block to idle without a timeout.
- R5: In active, key 0xA5C6 moves to service. In service, key 0xDA7E moves back to active and clears the counter to zero on that clock edge.
- R6: In active or service, a control write with any other key causes a timeout at that clock edge. The flag (bit 15) and the reset request are high from the next cycle.
- R7: When armed and configured, a counter equal to the period causes a timeout on the following edge. The flag reads 1 at bit 15 and the counter stays frozen at the period value.
- R8: The reset request stays high for exactly PULSE_LEN (default 16) cycles per timeout, and a further timeout does not extend a pulse that is in progress.
- R9: Outside idle, writes to the counter (0x10, 0x14), period (0x18, 0x1C), timer control and global control registers are ignored. The enable bit cannot be cleared and the block never returns to idle from active or service.
- R10: A control write with bit 15 set clears the flag. Such a write does not start a new timeout while the flag is set.
- R11: A read of the counter low word (0x10) captures the high half. A read of 0x14 returns the captured value, not the live counter.
- R12: With period 0 and counter 0, the first armed cycle causes a timeout, so the reset request is high one cycle after the confirm write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Register byte address |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (captures the counter high half on a low-word read) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| resetReq | output | 1 | Reset request pulse, PULSE_LEN cycles long |

## Verification
The hardest case to reach is a timeout that must land on an exact cycle while the block is armed. Once armed, the period and mode can no longer be changed, so each timeout test starts from a hardware reset, writes the full configuration and arms with the two keys. It then counts falling clock edges from the confirm write to predict the cycle the flag rises. Randomly timed services at a large period check the live counter value against the bench's elapsed-cycle count after each service. Directed wrong-key writes in active and service, a zero period, and a flag clear in the middle of an armed run cover the remaining corners.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  typedef enum logic [1:0] {
    WD_IDLE    = 2'd0,
    WD_PRE     = 2'd1,
    WD_ACTIVE  = 2'd2,
    WD_SERVICE = 2'd3
  } wdState_e;

  localparam logic [15:0] KEY_ARM     = 16'hA5C6;
  localparam logic [15:0] KEY_CONFIRM = 16'hDA7E;

  localparam int OFS_ID     = 'h00;
  localparam int OFS_EMU    = 'h04;
  localparam int OFS_CNT_LO = 'h10;
  localparam int OFS_CNT_HI = 'h14;
  localparam int OFS_PRD_LO = 'h18;
  localparam int OFS_PRD_HI = 'h1C;
  localparam int OFS_TCTL   = 'h20;
  localparam int OFS_GCTL   = 'h24;
  localparam int OFS_WDCTL  = 'h28;

  localparam logic [1:0] RUN_CONTINUOUS = 2'd2;
  localparam logic [1:0] MODE_WATCHDOG  = 2'd2;
  localparam logic [1:0] HALVES_RELEASE = 2'b11;

  typedef struct packed {
    logic cntLoWr;
    logic cntHiWr;
    logic prdLoWr;
    logic prdHiWr;
    logic cntClear;
    logic cntRun;
    logic hiCapture;
  } dpStrobe_t;

endpackage

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [CNT_W/2-1:0]  wrData,
  output logic [CNT_W/2-1:0]  cntLo,
  output logic [CNT_W-1:0]    prdVal,
  output logic [CNT_W/2-1:0]  hiSnap,
  output logic                hit
);
  localparam int HALF_W = CNT_W / 2;

  logic [CNT_W-1:0]  cnt;
  logic [HALF_W-1:0] prdHalf [2];
  logic [1:0]        prdWr;

  assign prdWr = {strb.prdHiWr, strb.prdLoWr};

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strb.cntClear)  cnt <= '0;
    else if (strb.cntLoWr)   cnt[HALF_W-1:0] <= wrData;
    else if (strb.cntHiWr)   cnt[CNT_W-1:HALF_W] <= wrData;
    else if (strb.cntRun)    cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < 2; g++) begin : gPrd
    always_ff @(posedge clk) begin
      if (!rstN)         prdHalf[g] <= '0;
      else if (prdWr[g]) prdHalf[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               hiSnap <= '0;
    else if (strb.hiCapture) hiSnap <= cnt[CNT_W-1:HALF_W];
  end

  assign prdVal = {prdHalf[1], prdHalf[0]};
  assign cntLo  = cnt[HALF_W-1:0];
  assign hit    = (cnt == prdVal);

endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          DATA_W    = 32,
  parameter int          PULSE_LEN = 16,
  parameter logic [31:0] ID_VALUE  = 32'h0057_D064
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [15:0]         keyIn,
  input  logic                flagIn,
  input  logic                enIn,
  input  logic [1:0]          runModeIn,
  input  logic [3:0]          gctlIn,
  output logic [DATA_W-1:0]   busRdata,
  output logic                resetReq,
  input  logic                hit,
  input  logic [DATA_W-1:0]   cntLo,
  input  logic [2*DATA_W-1:0] prdVal,
  input  logic [DATA_W-1:0]   hiSnap,
  output dpStrobe_t           strb,
  output wdState_e            wdState,
  output logic                toFlag
);
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic selId, selEmu, selCntLo, selCntHi, selPrdLo, selPrdHi, selTctl, selGctl, selWd;
  logic unlocked, armed, modeOk, wdWr, badKey, svcDone, toEvent;
  logic [1:0] tctlMode;
  logic [3:0] gctl;
  logic [PULSE_W-1:0] pulseCnt;
  wdState_e nextState;

  assign selId    = busAddr == ADDR_W'(OFS_ID);
  assign selEmu   = busAddr == ADDR_W'(OFS_EMU);
  assign selCntLo = busAddr == ADDR_W'(OFS_CNT_LO);
  assign selCntHi = busAddr == ADDR_W'(OFS_CNT_HI);
  assign selPrdLo = busAddr == ADDR_W'(OFS_PRD_LO);
  assign selPrdHi = busAddr == ADDR_W'(OFS_PRD_HI);
  assign selTctl  = busAddr == ADDR_W'(OFS_TCTL);
  assign selGctl  = busAddr == ADDR_W'(OFS_GCTL);
  assign selWd    = busAddr == ADDR_W'(OFS_WDCTL);

  assign unlocked = (wdState == WD_IDLE);
  assign armed    = (wdState == WD_ACTIVE) || (wdState == WD_SERVICE);
  assign wdWr     = busWe && selWd;
  assign modeOk   = (gctl[3:2] == MODE_WATCHDOG) && (gctl[1:0] == HALVES_RELEASE)
                    && (tctlMode == RUN_CONTINUOUS);

  always_comb begin
    nextState = wdState;
    badKey    = 1'b0;
    svcDone   = 1'b0;
    if (wdWr) begin
      unique case (wdState)
        WD_IDLE:    if (keyIn == KEY_ARM && enIn) nextState = WD_PRE;
        WD_PRE:     nextState = (keyIn == KEY_CONFIRM && enIn) ? WD_ACTIVE : WD_IDLE;
        WD_ACTIVE:  if (keyIn == KEY_ARM) nextState = WD_SERVICE;
                    else badKey = 1'b1;
        WD_SERVICE: begin
          nextState = WD_ACTIVE;
          if (keyIn == KEY_CONFIRM) svcDone = 1'b1;
          else badKey = 1'b1;
        end
        default:    nextState = WD_IDLE;
      endcase
    end
  end

  assign toEvent = !toFlag && ((armed && modeOk && hit) || badKey);

  always_ff @(posedge clk) begin
    if (!rstN) wdState <= WD_IDLE;
    else       wdState <= nextState;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                toFlag <= 1'b0;
    else if (toEvent)         toFlag <= 1'b1;
    else if (wdWr && flagIn)  toFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              pulseCnt <= '0;
    else if (toEvent && pulseCnt == '0)     pulseCnt <= PULSE_W'(PULSE_LEN);
    else if (pulseCnt != '0)                pulseCnt <= pulseCnt - 1'b1;
  end
  assign resetReq = (pulseCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tctlMode <= '0;
      gctl     <= '0;
    end else if (busWe && unlocked) begin
      if (selTctl) tctlMode <= runModeIn;
      if (selGctl) gctl     <= gctlIn;
    end
  end

  always_comb begin
    strb           = '0;
    strb.cntLoWr   = busWe && unlocked && selCntLo;
    strb.cntHiWr   = busWe && unlocked && selCntHi;
    strb.prdLoWr   = busWe && unlocked && selPrdLo;
    strb.prdHiWr   = busWe && unlocked && selPrdHi;
    strb.cntClear  = svcDone;
    strb.cntRun    = armed && modeOk && !toFlag && !hit;
    strb.hiCapture = busRe && selCntLo;
  end

  always_comb begin
    busRdata = '0;
    if (selId)    busRdata = ID_VALUE;
    if (selEmu)   busRdata = '0;
    if (selCntLo) busRdata = cntLo;
    if (selCntHi) busRdata = hiSnap;
    if (selPrdLo) busRdata = prdVal[DATA_W-1:0];
    if (selPrdHi) busRdata = prdVal[2*DATA_W-1:DATA_W];
    if (selTctl)  busRdata = DATA_W'({tctlMode, 6'b0});
    if (selGctl)  busRdata = DATA_W'(gctl);
    if (selWd)    busRdata = DATA_W'({toFlag, !unlocked, 14'b0});
  end

endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import kwd_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          PULSE_LEN = 16,
  parameter logic [31:0] ID_VALUE  = 32'h0057_D064
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              resetReq
);
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;

  dpStrobe_t          strb;
  wdState_e           wdState;
  logic               toFlag;
  logic               hit;
  logic [DATA_W-1:0]  cntLo;
  logic [DATA_W-1:0]  hiSnap;
  logic [CNT_W-1:0]   prdVal;

  kwd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN), .ID_VALUE(ID_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .keyIn(busWdata[31:16]), .flagIn(busWdata[15]), .enIn(busWdata[14]),
    .runModeIn(busWdata[7:6]), .gctlIn(busWdata[3:0]),
    .busRdata(busRdata), .resetReq(resetReq), .hit(hit), .cntLo(cntLo),
    .prdVal(prdVal), .hiSnap(hiSnap), .strb(strb), .wdState(wdState), .toFlag(toFlag)
  );

  kwd_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(busWdata),
    .cntLo(cntLo), .prdVal(prdVal), .hiSnap(hiSnap), .hit(hit)
  );

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
  import kwd_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [15:0]       busKey,
  input logic              busEn,
  input logic              resetReq,
  input wdState_e          wdState,
  input logic              toFlag,
  input logic [63:0]       prdVal
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);
  logic [RUN_W-1:0] highRun;
  logic wdWr;

  assign wdWr = busWe && (busAddr == ADDR_W'(OFS_WDCTL));

  always_ff @(posedge clk) begin
    if (!rstN)         highRun <= '0;
    else if (resetReq) highRun <= (highRun == RUN_W'(PULSE_LEN + 1)) ? highRun : highRun + 1'b1;
    else               highRun <= '0;
  end

  assert_pulse_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> toFlag);

  assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> highRun < RUN_W'(PULSE_LEN));

  assert_pulse_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetReq) |-> highRun == RUN_W'(PULSE_LEN));

  assert_period_lock_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wdState != WD_IDLE && busWe && busAddr == ADDR_W'(OFS_PRD_LO)) |=> $stable(prdVal));

  assert_no_disarm_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wdState == WD_ACTIVE || wdState == WD_SERVICE) |=> wdState != WD_IDLE);

  assert_pre_abort_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wdState == WD_PRE && wdWr && (busKey != KEY_CONFIRM || !busEn))
      |=> (wdState == WD_IDLE && !resetReq));

  assert_bad_key_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wdState == WD_ACTIVE && !toFlag && wdWr && busKey != KEY_ARM) |=> toFlag);

endmodule

bind key_watchdog kwd_checker #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
  .busKey(busWdata[31:16]), .busEn(busWdata[14]), .resetReq(resetReq),
  .wdState(wdState), .toFlag(toFlag), .prdVal(prdVal)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  localparam int          PULSE = 16;
  localparam logic [31:0] IDV   = 32'h0057_D064;
  localparam logic [5:0] A_ID = 6'h00, A_EMU = 6'h04, A_CLO = 6'h10, A_CHI = 6'h14,
                         A_PLO = 6'h18, A_PHI = 6'h1C, A_TC = 6'h20, A_GC = 6'h24, A_WD = 6'h28;
  localparam logic [31:0] ARM_EN = 32'hA5C6_4000, CONF_EN = 32'hDA7E_4000;
  localparam logic [31:0] ARM_NOEN = 32'hA5C6_0000, CONF_NOEN = 32'hDA7E_0000;

  logic clk = 0, rstN = 0, busWe = 0, busRe = 0, resetReq;
  logic [5:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  int errors = 0, checks = 0;

  key_watchdog #(.PULSE_LEN(PULSE), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .resetReq(resetReq));

  always #4 clk = ~clk;

  function automatic logic [31:0] expWd(input logic flag, input logic en);
    return {16'h0, flag, en, 14'h0};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1;
    @(negedge clk);
    busWe = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 0;
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic goodConfig(input logic [31:0] prdLo);
    wr(A_GC, 32'hB);
    wr(A_TC, 32'h80);
    wr(A_PLO, prdLo);
    wr(A_PHI, 32'h0);
  endtask

  task automatic countPulse(input string tag, input int already);
    int highs = already;
    for (int i = 0; i < PULSE + 4; i++) begin
      @(negedge clk);
      if (resetReq) highs++;
    end
    check(tag, highs, PULSE);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d, seedv;
    seedv = $urandom(32'h5EED_0042);
    doReset();

    // R1 reset state
    rd(A_ID, d);  check("R1 id", d, IDV);
    rd(A_WD, d);  check("R1 wdctl", d, 32'h0);
    rd(A_PLO, d); check("R1 period", d, 32'h0);
    rd(A_CLO, d); check("R1 counter", d, 32'h0);
    rd(A_EMU, d); check("R1 emu", d, 32'h0);
    check("R1 resetReq", resetReq, 1'b0);

    // R11 high-half capture
    wr(A_CHI, 32'h5);
    rd(A_CHI, d); check("R11 stale high", d, 32'h0);
    wr(A_CLO, 32'h11);
    rd(A_CLO, d); check("R11 low", d, 32'h11);
    rd(A_CHI, d); check("R11 captured high", d, 32'h5);

    // R2 / R4 arming handshake
    wr(A_WD, ARM_NOEN);
    rd(A_WD, d); check("R2 no enable stays idle", d, expWd(0, 0));
    wr(A_WD, ARM_EN);
    rd(A_WD, d); check("R2 pre-active", d, expWd(0, 1));
    wr(A_WD, 32'h1111_4000);
    rd(A_WD, d); check("R4 wrong key to idle", d, expWd(0, 0));
    check("R4 no reset", resetReq, 1'b0);
    wr(A_WD, ARM_EN);
    wr(A_WD, CONF_NOEN);
    rd(A_WD, d); check("R4 confirm without enable", d, expWd(0, 0));

    // R3 wrong config: counter holds
    doReset();
    wr(A_GC, 32'h9); wr(A_TC, 32'h80); wr(A_PLO, 32'h3);
    wr(A_WD, ARM_EN); wr(A_WD, CONF_EN);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (resetReq) seen++; end
      check("R3 no timeout", seen, 0);
    end
    rd(A_CLO, d); check("R3 counter held", d, 32'h0);

    // R12 zero period
    doReset();
    goodConfig(32'h0);
    wr(A_WD, ARM_EN); wr(A_WD, CONF_EN);
    check("R12 before", resetReq, 1'b0);
    @(negedge clk);
    check("R12 immediate timeout", resetReq, 1'b1);
    countPulse("R8 pulse length zero period", 1);

    // R7 timeout on period, R8, R9 lock
    doReset();
    goodConfig(32'd20);
    wr(A_WD, ARM_EN); wr(A_WD, CONF_EN);
    repeat (20) @(negedge clk);
    check("R7 not yet", resetReq, 1'b0);
    @(negedge clk);
    check("R7 timeout", resetReq, 1'b1);
    countPulse("R8 pulse length", 1);
    rd(A_WD, d); check("R7 flag", d, expWd(1, 1));
    rd(A_CLO, d); check("R7 counter frozen", d, 32'd20);
    wr(A_PLO, 32'h5);   rd(A_PLO, d); check("R9 period locked", d, 32'd20);
    wr(A_GC, 32'h0);    rd(A_GC, d);  check("R9 gctl locked", d, 32'hB);
    wr(A_TC, 32'h0);    rd(A_TC, d);  check("R9 tctl locked", d, 32'h80);
    wr(A_CLO, 32'h0);   rd(A_CLO, d); check("R9 counter locked", d, 32'd20);

    // R5 random servicing at a large period
    doReset();
    goodConfig(32'd1000);
    wr(A_WD, ARM_EN); wr(A_WD, CONF_EN);
    for (int it = 0; it < 25; it++) begin
      int dly;
      dly = $urandom_range(0, 30);
      wr(A_WD, ($urandom_range(0, 1) == 1) ? ARM_NOEN : ARM_EN);
      rd(A_WD, d); check("R9 enable stays set in service", d, expWd(0, 1));
      wr(A_WD, CONF_NOEN);
      repeat (dly) @(negedge clk);
      rd(A_CLO, d); check("R5 counter after service", d, 32'(dly + 1));
      rd(A_CHI, d); check("R5 counter high", d, 32'h0);
      check("R5 no reset", resetReq, 1'b0);
    end

    // R6 bad key in service
    wr(A_WD, ARM_EN);
    wr(A_WD, 32'h1234_4000);
    check("R6 service bad key reset", resetReq, 1'b1);
    rd(A_WD, d); check("R6 flag", d, expWd(1, 1));
    repeat (PULSE + 2) @(negedge clk);

    // R10 flag clear
    wr(A_WD, 32'h0000_8000);
    check("R10 no new reset", resetReq, 1'b0);
    rd(A_WD, d); check("R10 flag cleared", d, expWd(0, 1));

    // R6 bad key in active
    wr(A_WD, 32'hBEEF_0000);
    check("R6 active bad key reset", resetReq, 1'b1);
    rd(A_WD, d); check("R6 active flag", d, expWd(1, 1));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule